// File: doc/BRIEF.md
# Inter-Core Interrupt and Mailbox Send Engine

The engine takes 64-bit commands from a write-only command port and turns each one into transfers on a master bus that reaches the register block of one core. Three kinds of command exist. An interrupt command sets one bit in the target core's interrupt set register. A mailbox command writes one of eight mailbox words. An any-address command writes an arbitrary 16-bit address on the target.

A 4-bit byte mask inside the command decides how a mailbox or any-address command writes the target word. A set mask bit keeps the matching byte of the word already held at the target. A clear mask bit takes that byte from the command payload. When the mask is zero, the payload is written straight through and no read is made. When any mask bit is set, the engine reads the target word, merges it with the payload and writes the result back.

The engine handles one command at a time. Command-port ready is low from acceptance until the final write is acknowledged. The command is registered when it is accepted, so the command-port inputs may change freely while the engine is busy.

Top module: `ipi_send_engine`

## Requirements
- R1: After reset, cmd_ready_o is 1 and bus_req_o is 0.
- R2: A command is acted on only when cmd_be_i is 8'hFF and cmd_kind_i is not 3. Any other command is consumed with cmd_ready_o staying 1 and produces no bus transfer. The kind codes are 0 for interrupt, 1 for mailbox, 2 for any-address and 3 for reserved.
- R3: Every bus transfer of a command carries cmd_data_i[25:16] on bus_core_o.
- R4: An interrupt command makes one write and no read. The write goes to address 16'h1008 with data 1 << cmd_data_i[4:0].
- R5: A mailbox command uses address 16'h1020 + 4*cmd_data_i[4:2]. All other low command bits are ignored.
- R6: An any-address command uses address cmd_data_i[15:0].
- R7: For a mailbox or any-address command whose mask cmd_data_i[30:27] is zero, the engine makes no read and one write of the payload cmd_data_i[63:32].
- R8: For a mailbox or any-address command with a nonzero mask, the engine makes one read and then one write to the same core and address. Byte i of the written word is byte i of the read data when mask bit i is 1, and byte i of the payload otherwise.
- R9: cmd_ready_o is 0 from acceptance until the last write is acknowledged. A command presented during that time is ignored.
- R10: A change on cmd_data_i or cmd_kind_i after acceptance does not affect the transfers of the command in flight.
- R11: While bus_req_o is high and bus_ack_i is low, bus_we_o, bus_core_o, bus_addr_o and bus_wdata_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command write present |
| cmd_ready_o | output | 1 | Engine idle, able to take a command |
| cmd_be_i | input | 8 | Byte enables of the command write |
| cmd_kind_i | input | 2 | 0 interrupt, 1 mailbox, 2 any-address, 3 reserved |
| cmd_data_i | input | 64 | Command word |
| bus_req_o | output | 1 | Master transfer request, held until acknowledged |
| bus_we_o | output | 1 | 1 for a write, 0 for a read |
| bus_core_o | output | 10 | Target core id |
| bus_addr_o | output | 16 | Target register address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Transfer done; read data is valid when this is high |
| bus_rdata_i | input | 32 | Read data |

## Verification
The bench builds the engine with its default widths: a 10-bit core id, 16-bit addresses and 32-bit words with a 4-bit byte mask. These widths make it small enough to sweep completely. All 32 interrupt vectors are sent. All 16 masks are crossed with all 8 mailbox words, and all 16 masks are sent on several any-address targets. Bus acknowledge latency varies from 0 to 2 cycles, which exercises the hold rule while a request waits. Noise commands are driven while the engine is busy, and partial byte enables and the reserved kind are presented to cover the rejection paths.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    KIND_IRQ  = 2'd0,
    KIND_MAIL = 2'd1,
    KIND_ANY  = 2'd2,
    KIND_RSVD = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MERGE = 2'd2,
    ST_WRITE = 2'd3
  } eng_state_e;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
#(
  parameter int CMD_W     = 64,
  parameter int CORE_W    = 10,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int VEC_W     = 5,
  parameter int CORE_LSB  = 16,
  parameter int MASK_LSB  = 27,
  parameter logic [ADDR_W-1:0] SET_ADDR  = 16'h1008,
  parameter logic [ADDR_W-1:0] MBOX_BASE = 16'h1020,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [1:0]        kind_i,
  output logic              kind_ok_o,
  output logic [CORE_W-1:0] core_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [DATA_W-1:0] payload_o
);
  logic [DATA_W-1:0] onehot;
  logic [ADDR_W-1:0] mbox_off;

  always_comb begin
    onehot = '0;
    onehot[cmd_i[VEC_W-1:0]] = 1'b1;
    mbox_off = '0;
    mbox_off[4:2] = cmd_i[4:2];
  end

  assign core_o    = cmd_i[CORE_LSB +: CORE_W];
  assign kind_ok_o = (cmd_kind_e'(kind_i) != KIND_RSVD);

  always_comb begin
    unique case (cmd_kind_e'(kind_i))
      KIND_IRQ: begin
        addr_o    = SET_ADDR;
        mask_o    = '0;
        payload_o = onehot;
      end
      KIND_MAIL: begin
        addr_o    = MBOX_BASE + mbox_off;
        mask_o    = cmd_i[MASK_LSB +: MASK_W];
        payload_o = cmd_i[CMD_W-1 -: DATA_W];
      end
      default: begin
        addr_o    = cmd_i[ADDR_W-1:0];
        mask_o    = cmd_i[MASK_LSB +: MASK_W];
        payload_o = cmd_i[CMD_W-1 -: DATA_W];
      end
    endcase
  end
endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge #(
  parameter int DATA_W = 32,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [MASK_W-1:0] keep_i,
  output logic [DATA_W-1:0] merged_o
);
  for (genvar b = 0; b < MASK_W; b++) begin : g_byte
    assign merged_o[b*8 +: 8] = keep_i[b] ? old_i[b*8 +: 8] : new_i[b*8 +: 8];
  end
endmodule

// File: rtl/ipi_rmw_fsm.sv
module ipi_rmw_fsm
  import ipi_pkg::*;
#(
  parameter int CORE_W = 10,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [CORE_W-1:0] core_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [DATA_W-1:0] payload_i,
  output logic              idle_o,
  output logic              req_o,
  output logic              we_o,
  output logic [CORE_W-1:0] core_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i
);
  eng_state_e        state_q;
  logic [CORE_W-1:0] core_q;
  logic [ADDR_W-1:0] addr_q;
  logic [MASK_W-1:0] mask_q;
  logic [DATA_W-1:0] pay_q, old_q, wdata_q, merged;

  ipi_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .old_i   (old_q),
    .new_i   (pay_q),
    .keep_i  (mask_q),
    .merged_o(merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      core_q  <= '0;
      addr_q  <= '0;
      mask_q  <= '0;
      pay_q   <= '0;
      old_q   <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch_i) begin
          core_q  <= core_i;
          addr_q  <= addr_i;
          mask_q  <= mask_i;
          pay_q   <= payload_i;
          wdata_q <= payload_i;
          state_q <= (mask_i != '0) ? ST_READ : ST_WRITE;
        end
        ST_READ: if (ack_i) begin
          old_q   <= rdata_i;
          state_q <= ST_MERGE;
        end
        ST_MERGE: begin
          wdata_q <= merged;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o  = (state_q == ST_IDLE);
  assign req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign we_o    = (state_q == ST_WRITE);
  assign core_o  = core_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/ipi_send_engine.sv
module ipi_send_engine #(
  parameter int CMD_W  = 64,
  parameter int CORE_W = 10,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int BE_W  = CMD_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [BE_W-1:0]   cmd_be_i,
  input  logic [1:0]        cmd_kind_i,
  input  logic [CMD_W-1:0]  cmd_data_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [CORE_W-1:0] bus_core_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int MASK_W = DATA_W / 8;

  logic              kind_ok, launch;
  logic [CORE_W-1:0] dec_core;
  logic [ADDR_W-1:0] dec_addr;
  logic [MASK_W-1:0] dec_mask;
  logic [DATA_W-1:0] dec_pay;

  ipi_cmd_decode #(
    .CMD_W (CMD_W),
    .CORE_W(CORE_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dec (
    .cmd_i    (cmd_data_i),
    .kind_i   (cmd_kind_i),
    .kind_ok_o(kind_ok),
    .core_o   (dec_core),
    .addr_o   (dec_addr),
    .mask_o   (dec_mask),
    .payload_o(dec_pay)
  );

  // partial-width writes and the reserved kind are consumed silently
  assign launch = cmd_valid_i && cmd_ready_o && (cmd_be_i == '1) && kind_ok;

  ipi_rmw_fsm #(
    .CORE_W(CORE_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .core_i   (dec_core),
    .addr_i   (dec_addr),
    .mask_i   (dec_mask),
    .payload_i(dec_pay),
    .idle_o   (cmd_ready_o),
    .req_o    (bus_req_o),
    .we_o     (bus_we_o),
    .core_o   (bus_core_o),
    .addr_o   (bus_addr_o),
    .wdata_o  (bus_wdata_o),
    .ack_i    (bus_ack_i),
    .rdata_i  (bus_rdata_i)
  );
endmodule

// File: rtl/ipi_send_engine_chk.sv
module ipi_send_engine_chk #(
  parameter int CORE_W = 10,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BE_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic [BE_W-1:0]   cmd_be_i,
  input logic [1:0]        cmd_kind_i,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [CORE_W-1:0] bus_core_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ack_i
);
  // R9
  busy_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !cmd_ready_o);

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o) &&
      $stable(bus_core_o) && $stable(bus_addr_o) && $stable(bus_wdata_o)));

  // R8
  read_then_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o && bus_ack_i) |=> !bus_req_o ##1 (bus_req_o && bus_we_o));

  // R2
  reject_stays_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && ((cmd_be_i != '1) || (cmd_kind_i == 2'd3)))
      |=> (cmd_ready_o && !bus_req_o));

  // R9
  launch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && (cmd_be_i == '1) && (cmd_kind_i != 2'd3))
      |=> (!cmd_ready_o && $past(cmd_ready_o)));
endmodule

bind ipi_send_engine ipi_send_engine_chk #(
  .CORE_W(CORE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o),
  .cmd_be_i   (cmd_be_i),
  .cmd_kind_i (cmd_kind_i),
  .bus_req_o  (bus_req_o),
  .bus_we_o   (bus_we_o),
  .bus_core_o (bus_core_o),
  .bus_addr_o (bus_addr_o),
  .bus_wdata_o(bus_wdata_o),
  .bus_ack_i  (bus_ack_i)
);

// File: tb/ipi_send_engine_bench.sv
`timescale 1ns/1ps
module ipi_send_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [7:0]  cmd_be_i = 8'hFF;
  logic [1:0]  cmd_kind_i = 2'd0;
  logic [63:0] cmd_data_i = '0;
  logic        bus_req_o, bus_we_o;
  logic [9:0]  bus_core_o;
  logic [15:0] bus_addr_o;
  logic [31:0] bus_wdata_o;
  logic        bus_ack_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ipi_send_engine u_ipi_send_engine (.*);

  int tests = 0, fails = 0;
  bit done = 0;
  int lat = 0, wcnt = 0;
  int rd_n = 0, wr_n = 0, rd_before_wr = 0;
  logic [9:0]  r_core, w_core;
  logic [15:0] r_addr, w_addr;
  logic [31:0] w_data;

  function automatic logic [31:0] tgt_word(logic [9:0] c, logic [15:0] a);
    return {c[7:0] ^ 8'h5A, a[7:0], ~a[15:8], c[9:2] ^ 8'hC3};
  endfunction

  // bus responder and transfer log
  always @(negedge clk_i) begin
    bus_ack_i = 1'b0;
    if (bus_req_o) begin
      if (wcnt >= lat) begin
        bus_ack_i = 1'b1;
        wcnt = 0;
      end else wcnt++;
    end
    bus_rdata_i = tgt_word(bus_core_o, bus_addr_o);
    if (bus_req_o && bus_ack_i) begin
      if (bus_we_o) begin
        wr_n++; w_core = bus_core_o; w_addr = bus_addr_o; w_data = bus_wdata_o;
        rd_before_wr = rd_n;
      end else begin
        rd_n++; r_core = bus_core_o; r_addr = bus_addr_o;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one command and wait for the engine to return idle
  task automatic issue(logic [1:0] kind, logic [7:0] be, logic [63:0] data,
                       int l, bit noise);
    int n = 0;
    @(negedge clk_i);
    lat = l; wcnt = 0; rd_n = 0; wr_n = 0; rd_before_wr = 0;
    cmd_valid_i = 1'b1; cmd_kind_i = kind; cmd_be_i = be; cmd_data_i = data;
    @(negedge clk_i);
    cmd_valid_i = noise;
    if (noise) begin
      cmd_kind_i = 2'd0; cmd_be_i = 8'hFF; cmd_data_i = ~data;
    end
    while (!cmd_ready_o && n < 60) begin
      @(negedge clk_i);
      n++;
      if (noise) cmd_data_i = cmd_data_i + 64'h0001_0003_0005_0007;
    end
    cmd_valid_i = 1'b0;
    chk(n < 60, "R9 timeout", n, 60);
  endtask

  task automatic expect_cmd(logic [1:0] kind, logic [63:0] d, string tag);
    logic [9:0]  c = d[25:16];
    logic [3:0]  m = d[30:27];
    logic [31:0] p = d[63:32];
    logic [15:0] a;
    logic [31:0] exp, old;
    int reads;
    if (kind == 2'd0) begin
      a = 16'h1008; exp = 32'd1 << d[4:0]; reads = 0;
    end else begin
      a = (kind == 2'd1) ? 16'h1020 + {11'd0, d[4:2], 2'b00} : d[15:0];
      reads = (m != 0) ? 1 : 0;
      old = tgt_word(c, a);
      exp = p;
      for (int b = 0; b < 4; b++) if (m[b]) exp[b*8 +: 8] = old[b*8 +: 8];
    end
    chk(wr_n == 1 && rd_n == reads, {tag, " count"}, {rd_n[31:0], wr_n[31:0]},
        {reads[31:0], 32'd1});
    chk(w_core == c && w_addr == a, {tag, " R3 core/addr"}, {w_core, w_addr},
        {c, a});
    chk(w_data == exp, {tag, " data"}, w_data, exp);
    if (reads == 1) begin
      chk(r_core == c && r_addr == a && rd_before_wr == 1, {tag, " R8 read first"},
          {r_core, r_addr, rd_before_wr[7:0]}, {c, a, 8'd1});
    end
  endtask

  function automatic logic [63:0] mk(logic [31:0] p, logic [3:0] m,
                                     logic [9:0] c, logic [15:0] lo);
    logic [63:0] d = {p, 1'b1, m, 1'b0, c, lo};
    return d;
  endfunction

  initial begin
    repeat (20 * 6000) @(posedge clk_i);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk_i);
    chk(cmd_ready_o == 1'b1 && bus_req_o == 1'b0, "R1 reset",
        {cmd_ready_o, bus_req_o}, 2'b10);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cmd_ready_o == 1'b1 && bus_req_o == 1'b0, "R1 after release",
        {cmd_ready_o, bus_req_o}, 2'b10);

    // R4 every vector, two cores, with stray mask bits set
    for (int v = 0; v < 32; v++) begin
      d = mk(32'hDEAD_BEEF, 4'hF, (v[0] ? 10'h3FF : 10'h001), {11'h5A5, v[4:0]});
      issue(2'd0, 8'hFF, d, v % 3, 1'b0);
      expect_cmd(2'd0, d, "R4 irq");
    end

    // R5 R7 R8 all masks by all mailbox words
    for (int m = 0; m < 16; m++) begin
      for (int w = 0; w < 8; w++) begin
        d = mk(32'h1122_3344 ^ (m * 32'h0101_0101) ^ w, m[3:0], 10'(m * 37 + w),
               {11'h7FF, w[2:0], 2'b11});
        issue(2'd1, 8'hFF, d, (m + w) % 3, 1'b0);
        expect_cmd(2'd1, d, (m == 0) ? "R7 R5 mail" : "R8 R5 mail");
      end
    end

    // R6 R7 R8 any-address
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 4; k++) begin
        d = mk(32'hA5C3_0F96 + k, m[3:0], 10'(1000 - m * k), 16'(16'h1234 * (k + 1) + m));
        issue(2'd2, 8'hFF, d, k % 3, 1'b0);
        expect_cmd(2'd2, d, (m == 0) ? "R7 R6 any" : "R8 R6 any");
      end
    end

    // R9 R10 noise and input changes while busy
    d = mk(32'hCAFE_F00D, 4'b0101, 10'h2AB, 16'h4440);
    issue(2'd2, 8'hFF, d, 2, 1'b1);
    expect_cmd(2'd2, d, "R9 R10 busy any");
    d = mk(32'h0BAD_CAFE, 4'b0000, 10'h155, 16'h000C);
    issue(2'd1, 8'hFF, d, 1, 1'b1);
    expect_cmd(2'd1, d, "R9 R10 busy mail");

    // R2 rejections: partial byte enables and reserved kind
    d = mk(32'h1234_5678, 4'hF, 10'h010, 16'h2000);
    issue(2'd1, 8'h0F, d, 0, 1'b0);
    chk(wr_n == 0 && rd_n == 0 && cmd_ready_o, "R2 be 0F", {wr_n[7:0], rd_n[7:0]}, 0);
    issue(2'd0, 8'hF0, d, 0, 1'b0);
    chk(wr_n == 0 && rd_n == 0 && cmd_ready_o, "R2 be F0", {wr_n[7:0], rd_n[7:0]}, 0);
    issue(2'd2, 8'h7F, d, 0, 1'b0);
    chk(wr_n == 0 && rd_n == 0 && cmd_ready_o, "R2 be 7F", {wr_n[7:0], rd_n[7:0]}, 0);
    issue(2'd3, 8'hFF, d, 0, 1'b0);
    chk(wr_n == 0 && rd_n == 0 && cmd_ready_o, "R2 kind 3", {wr_n[7:0], rd_n[7:0]}, 0);
    repeat (3) @(negedge clk_i);
    chk(wr_n == 0 && bus_req_o == 0, "R2 quiet after reject", wr_n, 0);

    // R11 long latency read-modify-write
    d = mk(32'h8877_6655, 4'b1010, 10'h3C3, 16'h1F1C);
    issue(2'd1, 8'hFF, d, 2, 1'b0);
    expect_cmd(2'd1, d, "R11 slow mail");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule